// File: doc/BRIEF.md
# Quantized Line Feed-Forward Level Tracker

This block takes a stream of digitized samples of a rectified, scaled line voltage and sorts the line amplitude into one of eight feed-forward levels. Each sample is an unsigned millivolt value. For each level the block outputs a fixed fixed-point coefficient for a downstream multiplier. The level rises as soon as one sample exceeds a higher threshold. It falls only when a zero-crossing is detected. At that point the level is re-evaluated from the largest sample of the half-cycle that just ended, using thresholds lowered by 5% so that peaks sitting near a boundary do not make the level toggle.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is high at all times, and a sample is consumed in every cycle where `s_valid` is high. A separate one-cycle `tick` strobe, one per microsecond, times the zero-crossing window. The level, the coefficient and a change pulse are plain status outputs.

Top module: `qvff_level_tracker`

## Requirements
- R1: `s_ready` is high in every cycle, including during reset, and each sample with `s_valid` high is consumed in that cycle.
- R2: A rising code is the number of rising thresholds (1000, 1200, 1400, 1650, 1950, 2250, 2600 mV) at or below the sample. When an accepted sample's rising code is above `level`, `level` takes that code at the next edge, even if that skips several codes.
- R3: Without a zero-crossing, `level` never decreases, whatever the sample values.
- R4: A zero-crossing is declared once when ZC_TICKS (default 50) consecutive ticks occur with the latest sample below ZC_MV (default 700 mV). A run of 49 low-sample ticks followed by a sample at or above 700 mV declares nothing.
- R5: One cycle after a zero-crossing, `level` becomes the number of hysteresis thresholds at or below the half-cycle peak. A hysteresis threshold is a rising threshold minus one twentieth of it: 950, 1140, 1330, 1568, 1853, 2138, 2470 mV. This may move `level` down or up by several codes. The peak then restarts from the next sample.
- R6: `coeff` is an unsigned Q4.12 word fixed by `level`: codes 0 to 7 give 1630, 2458, 3437, 4735, 6570, 9007, 11969 and 15798.
- R7: `level_chg` is high for exactly the one cycle in which `level` differs from its previous value, and is low otherwise.
- R8: After reset, `level` is 0, `coeff` is 1630 and `level_chg` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, always high |
| s_data | input | SMP_W | Sample in millivolts, unsigned |
| tick | input | 1 | One-cycle strobe per microsecond |
| level | output | 3 | Current level code, 0 to 7 for levels 1 to 8 |
| coeff | output | COEF_W | Feed-forward coefficient, Q4.12 |
| level_chg | output | 1 | One-cycle pulse on each level change |

## Verification
Triangular half-cycles with a zero gap are used at peaks that climb through every band, and then at peaks that fall again. These runs separate immediate rising from re-evaluation at a zero-crossing, and they include peaks of 2500 mV and 2450 mV on either side of the top hysteresis edge. A slow step ramp around 1650 mV tells the exact rising boundary apart from the lower hysteresis edge, and shows that the level holds when samples drop back without a zero-crossing. A 49-tick dip is compared with a 50-tick gap after a sudden drop in amplitude, which confirms that only a complete window lowers the level, by two codes in one step.

// File: rtl/qvff_pkg.sv
package qvff_pkg;
  localparam int NLVL  = 8;
  localparam int LVL_W = $clog2(NLVL);
  localparam int NTHR  = NLVL - 1;

  function automatic int unsigned rise_thr(input int k);
    case (k)
      0: rise_thr = 1000;
      1: rise_thr = 1200;
      2: rise_thr = 1400;
      3: rise_thr = 1650;
      4: rise_thr = 1950;
      5: rise_thr = 2250;
      default: rise_thr = 2600;
    endcase
  endfunction

  function automatic int unsigned hyst_thr(input int k);
    hyst_thr = rise_thr(k) - rise_thr(k) / 20;
  endfunction

  function automatic logic [15:0] coeff_of(input logic [LVL_W-1:0] code);
    case (code)
      3'd0: coeff_of = 16'd1630;
      3'd1: coeff_of = 16'd2458;
      3'd2: coeff_of = 16'd3437;
      3'd3: coeff_of = 16'd4735;
      3'd4: coeff_of = 16'd6570;
      3'd5: coeff_of = 16'd9007;
      3'd6: coeff_of = 16'd11969;
      default: coeff_of = 16'd15798;
    endcase
  endfunction
endpackage

// File: rtl/qvff_zc_timer.sv
module qvff_zc_timer #(
  parameter int SMP_W    = 12,
  parameter int ZC_MV    = 700,
  parameter int ZC_TICKS = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [SMP_W-1:0] data,
  input  logic             tick,
  output logic             zc
);
  localparam int CNT_W = $clog2(ZC_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ZC_TICKS);

  logic             below_q;
  logic             below_n;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_high;
  logic             inc;

  assign hit_high = valid && (32'(data) >= 32'(ZC_MV));
  assign below_n  = valid ? !hit_high : below_q;
  assign inc      = tick && below_n && (cnt_q < CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q <= 1'b0;
      cnt_q   <= '0;
      zc      <= 1'b0;
    end else begin
      below_q <= below_n;
      zc      <= 1'b0;
      if (hit_high) begin
        cnt_q <= '0;
      end else if (inc) begin
        cnt_q <= cnt_q + 1'b1;
        zc    <= (cnt_q == CNT_MAX - 1'b1);
      end
    end
  end
endmodule

// File: rtl/qvff_peak_hold.sv
module qvff_peak_hold #(
  parameter int SMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [SMP_W-1:0] data,
  input  logic             clr,
  output logic [SMP_W-1:0] peak
);
  logic [SMP_W-1:0] base;

  assign base = clr ? '0 : peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak <= '0;
    end else if (valid && data > base) begin
      peak <= data;
    end else begin
      peak <= base;
    end
  end
endmodule

// File: rtl/qvff_level_ctl.sv
module qvff_level_ctl
  import qvff_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [SMP_W-1:0] data,
  input  logic             zc,
  input  logic [SMP_W-1:0] peak,
  output logic [LVL_W-1:0] level,
  output logic             chg
);
  logic [LVL_W-1:0] rise_code;
  logic [LVL_W-1:0] hyst_code;
  logic [LVL_W-1:0] base;
  logic [LVL_W-1:0] level_n;

  always_comb begin
    rise_code = '0;
    hyst_code = '0;
    for (int k = 0; k < NTHR; k++) begin
      if (32'(data) >= rise_thr(k)) rise_code = rise_code + 1'b1;
      if (32'(peak) >= hyst_thr(k)) hyst_code = hyst_code + 1'b1;
    end
  end

  always_comb begin
    base    = zc ? hyst_code : level;
    level_n = (valid && rise_code > base) ? rise_code : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      chg   <= 1'b0;
    end else begin
      level <= level_n;
      chg   <= (level_n != level);
    end
  end
endmodule

// File: rtl/qvff_level_tracker.sv
module qvff_level_tracker
  import qvff_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int COEF_W   = 16,
  parameter int ZC_MV    = 700,
  parameter int ZC_TICKS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SMP_W-1:0]  s_data,
  input  logic              tick,
  output logic [2:0]        level,
  output logic [COEF_W-1:0] coeff,
  output logic              level_chg
);
  logic             zc_pulse;
  logic [SMP_W-1:0] peak;

  assign s_ready = 1'b1;

  qvff_zc_timer #(.SMP_W(SMP_W), .ZC_MV(ZC_MV), .ZC_TICKS(ZC_TICKS)) u_zc (
    .clk(clk), .rst_n(rst_n), .valid(s_valid), .data(s_data),
    .tick(tick), .zc(zc_pulse)
  );

  qvff_peak_hold #(.SMP_W(SMP_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .valid(s_valid), .data(s_data),
    .clr(zc_pulse), .peak(peak)
  );

  qvff_level_ctl #(.SMP_W(SMP_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .valid(s_valid), .data(s_data),
    .zc(zc_pulse), .peak(peak), .level(level), .chg(level_chg)
  );

  assign coeff = COEF_W'(coeff_of(level));
endmodule

// File: rtl/qvff_level_tracker_chk.sv
module qvff_level_tracker_chk #(
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              zc,
  input logic [2:0]        level,
  input logic [COEF_W-1:0] coeff,
  input logic              level_chg
);
  a_r2_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (level > $past(level)) |-> ($past(s_valid) || $past(zc)));

  a_r3_fall_only_at_zc: assert property (@(posedge clk) disable iff (!rst_n)
    (level < $past(level)) |-> $past(zc));

  a_r4_zc_single: assert property (@(posedge clk) disable iff (!rst_n)
    zc |=> !zc);

  a_r6_coeff_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(level) |-> $stable(coeff));

  a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> level_chg);

  a_r7_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    level_chg |-> (level != $past(level)));
endmodule

bind qvff_level_tracker qvff_level_tracker_chk #(.COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .zc(zc_pulse),
  .level(level), .coeff(coeff), .level_chg(level_chg)
);

// File: tb/qvff_level_tracker_tb.sv
module qvff_level_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        tick = 1'b0;
  logic [2:0]  level;
  logic [15:0] coeff;
  logic        level_chg;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qvff_level_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .tick(tick), .level(level), .coeff(coeff),
    .level_chg(level_chg)
  );

  always @(negedge clk) if (rst_n && level_chg) pulses++;

  localparam int NV = 12;
  localparam logic [11:0] V_PEAK [NV] = '{
    12'd900, 12'd1100, 12'd1300, 12'd1500, 12'd1800, 12'd2100,
    12'd2400, 12'd2800, 12'd2500, 12'd2450, 12'd1000, 12'd940};
  localparam logic [2:0] V_CODE [NV] = '{
    3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd7, 3'd6, 3'd1, 3'd0};

  function automatic logic [15:0] exp_coeff(input logic [2:0] c);
    logic [15:0] t [8] = '{16'd1630, 16'd2458, 16'd3437, 16'd4735,
                           16'd6570, 16'd9007, 16'd11969, 16'd15798};
    return t[c];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int v);
    @(negedge clk);
    s_valid = 1'b1; tick = 1'b1; s_data = 12'(v);
    @(negedge clk);
    s_valid = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put_n(input int v, input int n);
    for (int i = 0; i < n; i++) put(v);
  endtask

  task automatic half_cycle(input int pk);
    for (int i = 0; i <= 40; i++) put(i * pk / 40);
    for (int i = 39; i >= 0; i--) put(i * pk / 40);
    put_n(0, 60);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R8, R1: state held in reset
    check("R1 ready in reset", int'(s_ready), 1);
    check("R8 level", int'(level), 0);
    check("R8 coeff", int'(coeff), 1630);
    check("R8 chg", int'(level_chg), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 rises, R5 re-evaluation, R6 coefficient
    for (int v = 0; v < NV; v++) begin
      half_cycle(int'(V_PEAK[v]));
      check($sformatf("R5 level peak=%0d", V_PEAK[v]), int'(level), int'(V_CODE[v]));
      check("R6 coeff", int'(coeff), int'(exp_coeff(V_CODE[v])));
      check("R1 ready", int'(s_ready), 1);
    end

    // R2 exact rising boundary around 1650, multi-step jump with one pulse (R7)
    p0 = pulses;
    put(1640);
    check("R2 multi-step rise", int'(level), 3);
    check("R7 one pulse for jump", pulses - p0, 1);
    put(1649);
    check("R2 below 1650", int'(level), 3);
    put(1650);
    check("R2 at 1650", int'(level), 4);
    p0 = pulses;
    put(1600);
    put(900);
    check("R3 no fall without zc", int'(level), 4);
    put_n(0, 60);
    check("R5 peak 1650 holds", int'(level), 4);
    check("R7 no pulse on hold", pulses - p0, 0);
    half_cycle(1600);
    check("R5 hysteresis 1600 holds", int'(level), 4);
    half_cycle(1567);
    check("R5 below 1568 falls", int'(level), 3);
    half_cycle(1568);
    check("R5 at 1568 rises at zc", int'(level), 4);

    // R4: short dip, then sudden drop with a full window
    half_cycle(2800);
    check("R2 level 7", int'(level), 7);
    put_n(2000, 5);
    put_n(0, 49);
    put_n(2000, 5);
    check("R4 49-tick dip ignored", int'(level), 7);
    put_n(0, 49);
    check("R4 49 ticks no zc", int'(level), 7);
    put(0);
    check("R4 50th tick zc, drop", int'(level), 5);
    check("R6 coeff after drop", int'(coeff), 9007);
    put_n(0, 30);
    check("R4 single zc, level kept", int'(level), 5);

    // R8: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 level after reset", int'(level), 0);
    check("R8 coeff after reset", int'(coeff), 1630);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule